// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses of one read or write burst for a double-data-rate SDRAM model or controller. A start strobe captures the start column, a burst length code and an ordering bit, all taken from a mode register image. From the next clock cycle onward, the block presents two column addresses per clock, one for each data edge, until the burst is complete.

Only the low log2(burst length) column bits move. They follow either a sequential order that wraps inside the aligned block, or an interleaved order formed by XOR with the beat index. The bits above that field keep their start value. A stop input ends a running burst at the next clock edge. A new start replaces the running burst at once. A reserved length code produces no beats and raises an error flag instead.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `beat_vld_o`, `burst_last_o`, `burst_done_o` and `len_err_o` are low.
- R2: Length code k with 1 <= k <= 4 selects a burst of 2^k beats. The beats appear two per cycle, starting in the cycle after the start edge, for 2^k/2 cycles. Lane 0 carries the even beat and lane 1 the odd beat.
- R3: With `order_i` = 0 (sequential), beat i carries low bits equal to (start + i) mod BL.
- R4: With `order_i` = 1 (interleaved), beat i carries low bits equal to start XOR i.
- R5: Column bits at and above position log2(BL) equal those of the start column on every beat.
- R6: `burst_last_o` is high only in the cycle that presents the final pair of a burst that runs to completion.
- R7: Length codes 0, 5, 6 and 7 are reserved. A start with a reserved code produces no beats and drives `len_err_o` high for exactly the next cycle. It also ends any running burst without a done pulse.
- R8: When `stop_i` is high at an edge where a pair is presented and there is no start, no beats and no last flag are presented in the following cycle.
- R9: `burst_done_o` pulses for one cycle directly after the final pair of a burst, or directly after a stop. There is no pulse when a start replaces the burst, and no pulse for a stop while idle.
- R10: A start during a burst takes priority over `stop_i`. It discards the remaining beats, and the new burst's first pair appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 9 | Start column address |
| len_code_i | input | 3 | Burst length code (k gives 2^k beats) |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminates the running burst |
| beat_col_o | output | 2x9 | Column per lane; lane 0 even beat, lane 1 odd beat |
| beat_vld_o | output | 1 | Both lanes carry a valid beat |
| burst_last_o | output | 1 | Presented pair is the final one |
| burst_done_o | output | 1 | Burst ended in the previous cycle |
| len_err_o | output | 1 | Previous start used a reserved length code |

## Verification
Bursts of every legal length are run in both orders, from aligned, unaligned and high-column starts. Unaligned starts show the wrap point and separate the modular add from the XOR. High starts such as 0x1FB show whether the upper bits stay frozen or a carry leaks into them. The mixed patterns cover a stop in mid-burst, a stop while idle, a restart in mid-burst, and a start together with a stop. They also include a reserved code during a burst and a start on the final pair. Together these separate a terminated burst from a completed one and from a replaced one.

// File: rtl/bcs_pkg.sv
// Package: shared types of the burst column sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package bcs_pkg;
    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } bcs_order_e;
endpackage

// File: rtl/bcs_len_decode.sv
// Module: turns a burst length code into log2(length), a legality flag and
// the index of the final beat pair.
// Assumes: code k means 2^k beats; lengths below one beat per lane are illegal.
module bcs_len_decode #(
    parameter int CODE_W   = 3,
    parameter int MAX_LOG  = 4,
    parameter int LANE_LOG = 1,
    parameter int LOG_W    = 3,
    parameter int PAIR_W   = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic [LOG_W-1:0]  log_o,
    output logic [PAIR_W-1:0] last_pair_o
);
    localparam int MIN_LOG = (LANE_LOG < 1) ? 1 : LANE_LOG;

    // Check the code range and derive the final pair index.
    always_comb begin
        legal_o     = (int'(code_i) >= MIN_LOG) && (int'(code_i) <= MAX_LOG);
        log_o       = legal_o ? LOG_W'(code_i) : LOG_W'(MIN_LOG);
        last_pair_o = PAIR_W'((1 << (int'(log_o) - LANE_LOG)) - 1);
    end
endmodule

// File: rtl/bcs_beat_addr.sv
// Module: column address of one beat, from the start column, the burst size
// and the beat index, under sequential wrap or XOR ordering.
// Assumes: beat_i < 2^log_i; bits above the burst field pass through.
module bcs_beat_addr
    import bcs_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4,
    parameter int LOG_W   = 3
) (
    input  logic [COL_W-1:0]   base_i,
    input  logic [LOG_W-1:0]   log_i,
    input  bcs_order_e         order_i,
    input  logic [MAX_LOG-1:0] beat_i,
    output logic [COL_W-1:0]   col_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] wrap_sum;
    logic [COL_W-1:0] flip;

    // Form both orderings and keep only the burst field from the chosen one.
    always_comb begin
        mask     = (COL_W'(1) << log_i) - COL_W'(1);
        beat_ext = COL_W'(beat_i);
        wrap_sum = base_i + beat_ext;
        flip     = base_i ^ beat_ext;
        col_o    = (base_i & ~mask) |
                   (((order_i == ORD_XOR) ? flip : wrap_sum) & mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
// Module: burst column sequencer. It captures a burst on start_i and presents
// LANES beats per cycle until the burst completes, is stopped, or is replaced.
// Assumes: LANES is a power of two, no larger than the shortest burst.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4,
    parameter int LANES   = 2,
    parameter int CODE_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [COL_W-1:0]            start_col_i,
    input  logic [CODE_W-1:0]           len_code_i,
    input  logic                        order_i,
    input  logic                        stop_i,
    output logic [LANES-1:0][COL_W-1:0] beat_col_o,
    output logic                        beat_vld_o,
    output logic                        burst_last_o,
    output logic                        burst_done_o,
    output logic                        len_err_o
);
    localparam int LANE_LOG = $clog2(LANES);
    localparam int PAIR_W   = MAX_LOG - LANE_LOG;
    localparam int LOG_W    = $clog2(MAX_LOG + 1);

    logic              dec_legal;
    logic [LOG_W-1:0]  dec_log;
    logic [PAIR_W-1:0] dec_last;

    logic              busy_q;
    logic [PAIR_W-1:0] pair_q;
    logic [PAIR_W-1:0] last_pair_q;
    logic [COL_W-1:0]  base_q;
    logic [LOG_W-1:0]  log_q;
    bcs_order_e        order_q;
    logic              done_q;
    logic              err_q;

    bcs_len_decode #(
        .CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .LANE_LOG(LANE_LOG),
        .LOG_W(LOG_W), .PAIR_W(PAIR_W)
    ) u_dec (
        .code_i(len_code_i), .legal_o(dec_legal),
        .log_o(dec_log), .last_pair_o(dec_last)
    );

    // Burst state: capture on start, step one pair per cycle, end on stop or last pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            pair_q      <= '0;
            last_pair_q <= '0;
            base_q      <= '0;
            log_q       <= '0;
            order_q     <= ORD_SEQ;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (start_i) begin
                if (dec_legal) begin
                    busy_q      <= 1'b1;
                    pair_q      <= '0;
                    last_pair_q <= dec_last;
                    base_q      <= start_col_i;
                    log_q       <= dec_log;
                    order_q     <= bcs_order_e'(order_i);
                end else begin
                    busy_q <= 1'b0;
                    err_q  <= 1'b1;
                end
            end else if (busy_q) begin
                if (stop_i || (pair_q == last_pair_q)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    pair_q <= pair_q + PAIR_W'(1);
                end
            end
        end
    end

    // One address generator per lane; lane g carries beat pair*LANES+g.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [MAX_LOG-1:0] beat_idx;
        assign beat_idx = MAX_LOG'(int'(pair_q) * LANES + g);
        bcs_beat_addr #(
            .COL_W(COL_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)
        ) u_addr (
            .base_i(base_q), .log_i(log_q), .order_i(order_q),
            .beat_i(beat_idx), .col_o(beat_col_o[g])
        );
    end

    // Output flags straight from the burst state.
    always_comb begin
        beat_vld_o   = busy_q;
        burst_last_o = busy_q && (pair_q == last_pair_q);
        burst_done_o = done_q;
        len_err_o    = err_q;
    end

    assert_reserved_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (len_code_i == '0)) |=> (len_err_o && !beat_vld_o));

    assert_err_no_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> !beat_vld_o);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && stop_i && !start_i) |=> (!beat_vld_o && !burst_last_o));

    assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_last_o && !start_i) |=> (burst_done_o && !beat_vld_o));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done_o |-> !beat_vld_o);

    assert_upper_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |-> (beat_col_o[0][COL_W-1:MAX_LOG] ==
                        beat_col_o[LANES-1][COL_W-1:MAX_LOG]));

    assert_upper_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && $past(beat_vld_o) && !$past(start_i)) |->
        $stable(beat_col_o[0][COL_W-1:MAX_LOG]));
endmodule

// File: tb/sim_burst_col_seq.sv
// Bench: queue-based reference of the expected beat pairs, compared every cycle.
module sim_burst_col_seq;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [8:0]       start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [1:0][8:0]  beat_col_o;
    logic             beat_vld_o, burst_last_o, burst_done_o, len_err_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct { int c0; int c1; bit xo; } pair_t;
    pair_t q[$];
    bit    e_done, e_err;

    always #2 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
        .beat_col_o(beat_col_o), .beat_vld_o(beat_vld_o),
        .burst_last_o(burst_last_o), .burst_done_o(burst_done_o),
        .len_err_o(len_err_o)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int col_of(int s, int lg, bit xo, int i);
        int mask = (1 << lg) - 1;
        int low  = xo ? ((s ^ i) & mask) : ((s + i) & mask);
        return (s & ~mask & 'h1FF) | low;
    endfunction

    // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(bit st, int col, int code, bit ord, bit sp);
        bit had;
        start_i = st; start_col_i = 9'(col); len_code_i = 3'(code);
        order_i = ord; stop_i = sp;
        @(posedge clk);
        had = (q.size() > 0);
        if (had) void'(q.pop_front());
        e_done = 0; e_err = 0;
        if (st) begin
            q.delete();
            if (code >= 1 && code <= 4) begin
                for (int k = 0; k < (1 << code); k += 2) begin
                    pair_t p;
                    p.c0 = col_of(col, code, ord, k);
                    p.c1 = col_of(col, code, ord, k + 1);
                    p.xo = ord;
                    q.push_back(p);
                end
            end else e_err = 1;
        end else if (had) begin
            if (sp) q.delete();
            if (q.size() == 0) e_done = 1;
        end
        @(negedge clk);
        chk(beat_vld_o == (q.size() > 0), "R2", "valid", beat_vld_o, q.size() > 0);
        if (q.size() > 0) begin
            chk(int'(beat_col_o[0]) == q[0].c0, q[0].xo ? "R4" : "R3", "lane0 col",
                beat_col_o[0], q[0].c0);
            chk(int'(beat_col_o[1]) == q[0].c1, q[0].xo ? "R4" : "R3", "lane1 col",
                beat_col_o[1], q[0].c1);
            chk(beat_col_o[0][8:4] == 5'(q[0].c0 >> 4), "R5", "upper bits",
                beat_col_o[0][8:4], q[0].c0 >> 4);
        end
        chk(burst_last_o == (q.size() == 1), "R6", "last", burst_last_o, q.size() == 1);
        chk(burst_done_o == e_done, "R9", "done", burst_done_o, e_done);
        chk(len_err_o == e_err, "R7", "error", len_err_o, e_err);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic run(int col, int code, bit ord);
        step(1, col, code, ord, 0);
        idle((code >= 1 && code <= 4) ? (1 << code) / 2 + 2 : 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!beat_vld_o && !burst_last_o && !burst_done_o && !len_err_o, "R1",
            "reset outputs", {beat_vld_o, burst_last_o, burst_done_o, len_err_o}, 0);
        rst_n = 1'b1;
        idle(2);
        run('h001, 2, 0);   // R3 wrap: 1,2,3,0
        run('h005, 3, 1);   // R4: 5,4,7,6,1,0,3,2
        run('h1FB, 4, 0);   // R5 high start, sequential wrap
        run('h0A7, 4, 1);   // R4 interleaved sixteen
        run('h003, 1, 0);   // R2 shortest burst
        run('h000, 1, 1);
        run('h012, 0, 0);   // R7 reserved codes
        run('h012, 5, 1);
        run('h012, 6, 0);
        run('h012, 7, 0);
        for (int code = 1; code <= 4; code++)
            for (int ord = 0; ord < 2; ord++)
                for (int s = 0; s < 3; s++)
                    run((s == 0) ? 0 : (s == 1) ? 'h13F : 'h0AA, code, 1'(ord));
        // R8: stop in mid-burst
        step(1, 'h044, 4, 0, 0); idle(2); step(0, 0, 0, 0, 1); idle(3);
        // R9: stop while idle gives no done
        step(0, 0, 0, 0, 1); idle(1);
        // R10: restart in mid-burst, then start together with stop
        step(1, 'h10E, 4, 1, 0); idle(2); step(1, 'h009, 2, 1, 0); idle(1);
        step(1, 'h0F1, 3, 0, 1); idle(6);
        // R7: reserved code ends a running burst without done
        step(1, 'h020, 4, 0, 0); idle(1); step(1, 'h020, 6, 0, 0); idle(2);
        // R10: start on the final pair
        step(1, 'h033, 2, 0, 0); idle(1); step(1, 'h1C2, 3, 1, 0); idle(6);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule